// File: doc/BRIEF.md
# Timer Capture Input Channel

This block forms the input half of a single capture/compare channel attached to a free-running timer. It picks a capture source from two external pins, a constant low level or a constant high level. In capture mode it watches that source for a chosen edge and copies the current timer count into a capture register when the edge arrives. The edge detector works either straight from the selected source, which is the asynchronous path, or from a copy of it passed through a two-flop synchroniser.

The channel also keeps a sampled copy of the selected source. That copy is refreshed whenever the compare-equal pulse is present at a clock edge. A channel flag is set by each capture in capture mode, or by the compare-equal pulse in compare mode. The flag reaches the interrupt output only when both the channel enable and the global enable are set. A capture that lands while the flag is still set marks a sticky overflow bit. The counter, the register bus and the output unit live outside this block.

Top module: `tmr_cap_chan`

## Requirements
- R1: `src_sel` picks the source: 0 is `in_a`, 1 is `in_b`, 2 is constant 0, 3 is constant 1. The level of the selected source appears at once on `stat[0]`.
- R2: While `cap_mode` is 0 (compare mode), no edge on any source and no value of `src_sel` changes `cap_val`, and no edge sets `flag`.
- R3: With `cap_mode` at 1, a qualifying edge copies `cnt` into `cap_val` and sets `flag`.
- R4: `edge_sel` picks the qualifying edge: 0 is none, 1 is rising, 2 is falling, 3 is both.
- R5: With `sync_sel` at 0, an edge on the source that is stable before a clock edge is captured at that same clock edge. With `sync_sel` at 1, the capture takes place two clock edges later.
- R6: `stat[1]` takes the level of the selected source at each clock edge where `equ` is 1, and holds its value otherwise.
- R7: `irq` is 1 only when `flag`, `ien` and `gie` are all 1.
- R8: Bit 2 of `stat` always reads as 0.
- R9: A capture that occurs while `flag` is already 1 sets the sticky overflow bit `stat[3]`. That bit stays set until `ovf_clr` is pulsed.
- R10: `flag_clr` clears `flag` at the next clock edge. A set event at the same edge wins over the clear. In compare mode, `equ` sets `flag`.
- R11: After reset, `cap_val`, `flag`, `irq` and all of `stat` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt | input | CW | Current timer count |
| cap_mode | input | 1 | 0 compare mode, 1 capture mode |
| sync_sel | input | 1 | 0 asynchronous capture, 1 synchronised capture |
| src_sel | input | 2 | Capture source select |
| edge_sel | input | 2 | Capture edge select |
| equ | input | 1 | Compare-equal pulse of this channel |
| ien | input | 1 | Channel interrupt enable |
| gie | input | 1 | Global interrupt enable |
| flag_clr | input | 1 | Clears the channel flag |
| ovf_clr | input | 1 | Clears the overflow bit |
| in_a | input | 1 | External capture input A |
| in_b | input | 1 | External capture input B |
| cap_val | output | CW | Captured timer count |
| flag | output | 1 | Channel interrupt flag |
| irq | output | 1 | Gated interrupt request |
| stat | output | 4 | {overflow, reserved 0, sampled input, live input} |

## Verification
The assertions assume that the external inputs are low while reset is held. Otherwise the first comparison against the cleared edge register would count as a rising edge. They also assume that `sync_sel` and `cap_mode` change only while the source is quiet, so that the edge detector never compares samples taken from two different paths. The stimulus sets every control field and waits several idle cycles before it moves a source. It keeps the inputs low through reset. It changes all inputs just after the falling clock edge, so each capture lands on a rising edge whose count the bench knows.

// File: rtl/tmr_cap_chan.sv
module tmr_cap_chan #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic          cap_mode,
  input  logic          sync_sel,
  input  logic [1:0]    src_sel,
  input  logic [1:0]    edge_sel,
  input  logic          equ,
  input  logic          ien,
  input  logic          gie,
  input  logic          flag_clr,
  input  logic          ovf_clr,
  input  logic          in_a,
  input  logic          in_b,
  output logic [CW-1:0] cap_val,
  output logic          flag,
  output logic          irq,
  output logic [3:0]    stat
);

  logic       src;
  logic [2:0] pipe;
  logic       cur, prv, rise, fall, hit;
  logic       smp, ovf;

  always_comb begin
    case (src_sel)
      2'd0:    src = in_a;
      2'd1:    src = in_b;
      2'd2:    src = 1'b0;
      default: src = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pipe <= '0;
    else        pipe <= {pipe[1:0], src};

  assign cur  = sync_sel ? pipe[1] : src;
  assign prv  = sync_sel ? pipe[2] : pipe[0];
  assign rise = cur & ~prv;
  assign fall = ~cur & prv;
  assign hit  = cap_mode & ((edge_sel[0] & rise) | (edge_sel[1] & fall));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_val <= '0;
      flag    <= 1'b0;
      ovf     <= 1'b0;
      smp     <= 1'b0;
    end else begin
      if (hit) cap_val <= cnt;
      flag <= hit | (~cap_mode & equ) | (flag & ~flag_clr);
      ovf  <= (hit & flag) | (ovf & ~ovf_clr);
      if (equ) smp <= src;
    end
  end

  assign irq  = flag & ien & gie;
  assign stat = {ovf, 1'b0, smp, src};

  AST_COMPARE_HOLDS_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cap_mode) |-> $stable(cap_val)); // R2

  AST_NO_EDGE_NO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(edge_sel) == 2'd0) |-> $stable(cap_val)); // R4

  AST_SAMPLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(equ) |-> $stable(stat[1])); // R6

  AST_OVF_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[3]) |-> $past(flag) && $past(cap_mode)); // R9

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stat[3]) |-> $past(ovf_clr)); // R9

  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past(flag_clr)); // R10

  AST_IRQ_NEEDS_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> gie && ien); // R7

endmodule

// File: tb/tmr_cap_chan_test.sv
module tmr_cap_chan_test;
  localparam int CW = 16;

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] cnt = 0;
  logic cap_mode = 0, sync_sel = 0, equ = 0, ien = 0, gie = 0;
  logic flag_clr = 0, ovf_clr = 0, in_a = 0, in_b = 0;
  logic [1:0] src_sel = 0, edge_sel = 0;
  logic [CW-1:0] cap_val;
  logic flag, irq;
  logic [3:0] stat;
  int checks = 0, fails = 0;
  logic [CW-1:0] mark;

  tmr_cap_chan #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .cnt(cnt), .cap_mode(cap_mode), .sync_sel(sync_sel),
    .src_sel(src_sel), .edge_sel(edge_sel), .equ(equ), .ien(ien), .gie(gie),
    .flag_clr(flag_clr), .ovf_clr(ovf_clr), .in_a(in_a), .in_b(in_b),
    .cap_val(cap_val), .flag(flag), .irq(irq), .stat(stat));

  always #5 clk = ~clk;
  always @(negedge clk) cnt <= cnt + 1'b1;

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); #1; end
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_flag();
    flag_clr = 1; ovf_clr = 1; step(1); flag_clr = 0; ovf_clr = 0; step(1);
  endtask

  task automatic t_reset();
    chk("R11 cap_val", cap_val, 0);
    chk("R11 flag", flag, 0);
    chk("R11 irq", irq, 0);
    chk("R11 stat", stat, 0);
  endtask

  task automatic t_select();
    in_a = 1; in_b = 0;
    src_sel = 0; #1 chk("R1 sel0", stat[0], 1);
    src_sel = 1; #1 chk("R1 sel1", stat[0], 0);
    in_b = 1;    #1 chk("R1 sel1 hi", stat[0], 1);
    src_sel = 2; #1 chk("R1 sel2", stat[0], 0);
    src_sel = 3; #1 chk("R1 sel3", stat[0], 1);
    chk("R8 reserved", stat[2], 0);
    in_a = 0; in_b = 0; src_sel = 0; step(4);
  endtask

  task automatic t_compare_ignore();
    cap_mode = 0; edge_sel = 3; step(3);
    mark = cap_val;
    in_a = 1; step(2); src_sel = 3; step(2); src_sel = 2; step(2); in_a = 0; src_sel = 0; step(3);
    chk("R2 cap unchanged", cap_val, mark);
    chk("R2 no flag", flag, 0);
  endtask

  task automatic t_edges();
    cap_mode = 1; sync_sel = 0; src_sel = 0; edge_sel = 1; step(3); clear_flag();
    mark = cnt; in_a = 1; step(1);
    chk("R3 R5 async rise cap", cap_val, mark);
    chk("R3 flag", flag, 1);
    clear_flag(); mark = cap_val; in_a = 0; step(2);
    chk("R4 rise ignores fall", cap_val, mark);
    chk("R4 no flag on fall", flag, 0);
    edge_sel = 2; step(2); in_a = 1; step(2);
    mark = cnt; in_a = 0; step(1);
    chk("R4 fall cap", cap_val, mark);
    clear_flag(); edge_sel = 3;
    mark = cnt; in_a = 1; step(1);
    chk("R4 both rise", cap_val, mark);
    step(2); clear_flag();
    mark = cnt; in_a = 0; step(1);
    chk("R4 both fall", cap_val, mark);
    clear_flag(); edge_sel = 0; mark = cap_val;
    in_a = 1; step(2); in_a = 0; step(2);
    chk("R4 none", cap_val, mark);
    chk("R4 none flag", flag, 0);
  endtask

  task automatic t_sync();
    cap_mode = 1; sync_sel = 1; edge_sel = 1; src_sel = 1; in_b = 0; step(4); clear_flag();
    mark = cnt; in_b = 1; step(2);
    chk("R5 sync not yet", flag, 0);
    step(1);
    chk("R5 sync cap", cap_val, mark + 2);
    chk("R5 sync flag", flag, 1);
    in_b = 0; step(4); clear_flag(); sync_sel = 0; src_sel = 0; step(3);
  endtask

  task automatic t_latch();
    cap_mode = 0; src_sel = 3; step(1);
    chk("R6 no equ yet", stat[1], 0);
    equ = 1; step(1); equ = 0;
    chk("R6 sampled hi", stat[1], 1);
    chk("R10 equ sets flag", flag, 1);
    src_sel = 2; step(2);
    chk("R6 hold", stat[1], 1);
    equ = 1; step(1); equ = 0;
    chk("R6 sampled lo", stat[1], 0);
    src_sel = 0; step(1);
  endtask

  task automatic t_irq();
    ien = 0; gie = 1; #1 chk("R7 ien off", irq, 0);
    ien = 1; gie = 0; #1 chk("R7 gie off", irq, 0);
    gie = 1; #1 chk("R7 both on", irq, 1);
    clear_flag(); chk("R7 flag off", irq, 0);
    ien = 0; gie = 0;
  endtask

  task automatic t_ovf_clr();
    cap_mode = 1; sync_sel = 0; edge_sel = 1; src_sel = 0; step(3); clear_flag();
    in_a = 1; step(1); in_a = 0; step(1);
    chk("R9 no ovf first", stat[3], 0);
    in_a = 1; step(1);
    chk("R9 ovf set", stat[3], 1);
    in_a = 0; flag_clr = 1; step(1); flag_clr = 0; step(3);
    chk("R9 ovf sticky", stat[3], 1);
    ovf_clr = 1; step(1); ovf_clr = 0;
    chk("R9 ovf cleared", stat[3], 0);
    flag_clr = 1; in_a = 1; step(1); flag_clr = 0;
    chk("R10 set wins", flag, 1);
    flag_clr = 1; step(1); flag_clr = 0;
    chk("R10 clear", flag, 0);
    in_a = 0; step(2);
  endtask

  initial begin
    fork
      begin
        step(3); rst_n = 1; step(1);
        t_reset();
        t_select();
        t_compare_ignore();
        t_edges();
        t_sync();
        t_latch();
        t_irq();
        t_ovf_clr();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule